// File: doc/BRIEF.md
# Four-Mode Universal Shift Register

This block is a register of parameterized width. Each stage is a single flop. The flop's next value comes from a four-way selector, and all stages share one two-bit mode code. In one clock edge the word can keep its value, move one place toward the least significant end, move one place toward the most significant end, or take a new parallel word. Shifting is steered only through the data path. Every flop sees the same free-running clock.

Each shift direction has its own serial input. A downward shift (toward bit 0) fills the most significant stage from `down_in`. An upward shift (toward the top bit) fills bit 0 from `up_in`. The bit that leaves the register in each direction is always visible on a serial output. A surrounding datapath can use the block as a serial-to-parallel converter, as a parallel-to-serial converter, as a scratch register, or as one link in a longer chain.

The block moves a single word under plain control pins. It has no streaming handshake: every edge applies the current mode.

Top module: `shift4_universal`

## Requirements
- R1: When `rst` is 1 at a rising clock edge, every bit of `q` becomes 0 on that edge, whatever `mode`, `par_in`, `up_in` and `down_in` are.
- R2: With `mode` = 2'b00 (hold), `q` keeps its value across the edge. Changes on `par_in`, `up_in` and `down_in` have no effect on it.
- R3: With `mode` = 2'b01 (shift down), bit i of `q` takes the old bit i+1, and the top bit takes `down_in`.
- R4: With `mode` = 2'b10 (shift up), bit i of `q` takes the old bit i-1, and bit 0 takes `up_in`.
- R5: With `mode` = 2'b11 (load), all bits of `q` take `par_in` on the same edge.
- R6: `up_out` always equals the top bit of `q`, which is the bit lost by the next upward shift. `down_out` always equals bit 0 of `q`, which is the bit lost by the next downward shift.
- R7: The width is the parameter `WIDTH`, with a default of 4 and a minimum of 2. Every mode behaves the same at any legal width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock, rising edge |
| rst | input | 1 | Synchronous clear, highest priority |
| mode | input | 2 | 00 hold, 01 shift down, 10 shift up, 11 load |
| par_in | input | WIDTH | Parallel word taken in load mode |
| up_in | input | 1 | Serial bit entering bit 0 on an upward shift |
| down_in | input | 1 | Serial bit entering the top bit on a downward shift |
| q | output | WIDTH | Stored word |
| up_out | output | 1 | Top bit of the stored word |
| down_out | output | 1 | Bit 0 of the stored word |

## Verification
Loads of alternating and single-bit words set up contents whose shifts differ from one another. A wrong neighbour connection or a swapped direction then shows up at once. Long runs of downward and upward shifts feed opposite values on the two serial inputs, which exposes any mix-up between `up_in` and `down_in` and any mix-up between the two serial outputs. Holds are run while the parallel and serial inputs toggle, to show that the inputs are ignored in that mode. Reset is asserted in the middle of a load to show that it takes priority. A long stretch of random modes and data is then compared against a bench reference model.

// File: rtl/usr_pkg.sv
package usr_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_DOWN = 2'b01,
    MODE_UP   = 2'b10,
    MODE_LOAD = 2'b11
  } usr_mode_t;

  // Four-way choice made by each stage.
  function automatic logic usr_pick(input usr_mode_t sel,
                                    input logic keep,
                                    input logic from_hi,
                                    input logic from_lo,
                                    input logic ld);
    logic r;
    case (sel)
      MODE_HOLD: r = keep;
      MODE_DOWN: r = from_hi;
      MODE_UP:   r = from_lo;
      default:   r = ld;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/usr_cell.sv
module usr_cell
  import usr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  usr_mode_t sel,
  input  logic      from_hi,
  input  logic      from_lo,
  input  logic      ld,
  output logic      bit_q
);

  logic nxt;

  always_comb nxt = usr_pick(sel, bit_q, from_hi, from_lo, ld);

  always_ff @(posedge clk) begin
    if (rst) bit_q <= 1'b0;
    else     bit_q <= nxt;
  end

endmodule

// File: rtl/shift4_universal.sv
module shift4_universal
  import usr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] par_in,
  input  logic             up_in,
  input  logic             down_in,
  output logic [WIDTH-1:0] q,
  output logic             up_out,
  output logic             down_out
);

  localparam int TOP = WIDTH - 1;

  usr_mode_t  sel;
  logic [TOP:0] hi_src;
  logic [TOP:0] lo_src;

  always_comb sel = usr_mode_t'(mode);

  // Neighbour wiring: downward shift pulls from above, upward from below.
  always_comb begin
    hi_src = {down_in, q[TOP:1]};
    lo_src = {q[TOP-1:0], up_in};
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    usr_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .sel     (sel),
      .from_hi (hi_src[i]),
      .from_lo (lo_src[i]),
      .ld      (par_in[i]),
      .bit_q   (q[i])
    );
  end

  assign up_out   = q[TOP];
  assign down_out = q[0];

  initial begin
    if (WIDTH < 2) $error("WIDTH must be at least 2");
  end

  // R1: synchronous clear beats every mode
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (q == '0));

  // R2: hold keeps the word
  a_r2_hold_keeps: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |=> (q == $past(q)));

  // R3: downward shift with top fill from down_in
  a_r3_down_shift: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01) |=> (q == {$past(down_in), $past(q[TOP:1])}));

  // R4: upward shift with bottom fill from up_in
  a_r4_up_shift: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10) |=> (q == {$past(q[TOP-1:0]), $past(up_in)}));

  // R5: load takes the whole parallel word
  a_r5_load_word: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11) |=> (q == $past(par_in)));

  // R6: a downward shift moves the old second bit onto down_out
  a_r6_down_out_follows: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01) |=> (down_out == $past(q[1])));

endmodule

// File: tb/tb_shift4_universal.sv
module tb_shift4_universal;

  localparam int W = 4;  // R7: default width

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   mode = 2'b00;
  logic [W-1:0] par_in = '0;
  logic         up_in = 1'b0;
  logic         down_in = 1'b0;
  logic [W-1:0] q;
  logic         up_out;
  logic         down_out;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] ref_q = '0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  always #4 clk = ~clk;

  shift4_universal #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .mode(mode), .par_in(par_in),
    .up_in(up_in), .down_in(down_in),
    .q(q), .up_out(up_out), .down_out(down_out)
  );

  // Driver: apply one cycle of stimulus and push the expected result.
  task automatic step(input logic r, input logic [1:0] m,
                      input logic [W-1:0] d, input logic ui, input logic di);
    string t;
    @(negedge clk);
    rst = r; mode = m; par_in = d; up_in = ui; down_in = di;
    if (r) begin
      ref_q = '0; t = "R1";
    end else begin
      case (m)
        2'b00: t = "R2";
        2'b01: begin ref_q = {di, ref_q[W-1:1]}; t = "R3"; end
        2'b10: begin ref_q = {ref_q[W-2:0], ui}; t = "R4"; end
        default: begin ref_q = d; t = "R5"; end
      endcase
    end
    exp_q.push_back(ref_q);
    tag_q.push_back(t);
  endtask

  // Monitor: compare after each edge.
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [W-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (q !== e) begin
        errors++;
        $display("FAIL %s: q actual %b expected %b", t, q, e);
      end
      checks++;
      if (up_out !== e[W-1] || down_out !== e[0]) begin
        errors++;
        $display("FAIL R6: up_out/down_out actual %b%b expected %b%b",
                 up_out, down_out, e[W-1], e[0]);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(1, 2'b11, 4'hF, 1, 1);             // R1 reset state
    step(0, 2'b11, 4'b1011, 0, 0);          // R5 load
    step(0, 2'b00, 4'b0100, 1, 1);          // R2 hold, inputs toggled
    step(0, 2'b00, 4'b1111, 0, 1);
    step(0, 2'b01, 4'h0, 1, 0);             // R3 down, opposite serial values
    step(0, 2'b01, 4'h0, 1, 1);
    step(0, 2'b01, 4'h0, 0, 0);
    step(0, 2'b10, 4'h0, 1, 0);             // R4 up
    step(0, 2'b10, 4'h0, 0, 1);
    step(0, 2'b10, 4'h0, 1, 0);
    step(0, 2'b11, 4'b0001, 0, 0);          // walking one up, R6 at top
    for (int i = 0; i < W; i++) step(0, 2'b10, 4'h0, 0, 1);
    step(0, 2'b11, 4'b1000, 1, 0);          // walking one down
    for (int i = 0; i < W; i++) step(0, 2'b01, 4'h0, 1, 0);
    step(0, 2'b11, 4'b1010, 0, 0);
    step(1, 2'b11, 4'b0101, 1, 1);          // R1 reset beats load
    step(0, 2'b00, 4'hF, 1, 1);             // R2 hold after reset
    for (int i = 0; i < 300; i++)           // mixed traffic
      step(($urandom % 23) == 0, 2'($urandom), W'($urandom),
           1'($urandom), 1'($urandom));
    step(0, 2'b00, 4'h0, 0, 0);
    wait (exp_q.size() == 0);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule